// File: doc/BRIEF.md
# Banked Data and Fetch Address Mapper

This block sits between a 16-bit processor core and its memories. It turns core addresses into physical targets. A data address falls into one of three regions, chosen by its top two bits:

- **Plain data:** addresses below the window go straight to on-chip data memory.
- **Mapped window:** a 16 KB window is redirected by a 16-bit data map value. The target is either instruction memory or one 16 KB slot of a 128 KB unified-memory segment.
- **I/O region:** the top quarter of the space. Only a small register block inside it is legal. Every other address there is flagged as a bus error.

Instruction fetch has its own path. The block holds the word program counter, which comes out of reset at a fixed vector. The byte address is the word PC times four. A separate instruction map value sends it either to instruction memory or to a unified segment, where the byte address is cut to the segment size.

Each unified target is checked against a segment-present mask, and a missing segment raises a bus error. Translation and error flags are combinational and valid in the same cycle. Only the program counter is a register.

Top module: `bank_addr_mapper`

## Requirements
- R1: A data address below 0x8000 gives target code 0 (data memory), offset equal to the address, segment 0 and no bus error.
- R2: A data address in 0x8000..0xBFFF with map bit 12 set gives target code 1 (instruction memory), segment 0, offset map[3:0]*0x4000 + address[13:0], and no bus error.
- R3: A data address in 0x8000..0xBFFF with map bit 12 clear gives target code 2 (unified memory), segment map[9:3], offset map[2:0]*0x4000 + address[13:0]. Map bits 15:13 and 11:10 have no effect on any output.
- R4: A data address in 0xC000..0xFFFF gives target code 0 with offset equal to the address. The bus error is low only when address[15:4] equals 0xFF0, so 0xFF00..0xFF0F are legal.
- R5: A unified target, data or fetch, whose segment bit in the 128-bit present mask is clear raises that path's bus error. The target, segment and offset stay as computed.
- R6: The boundaries land exactly: 0x7FFF is plain data, 0x8000 and 0xBFFF are in the window, and 0xC000 is in the I/O region.
- R7: The fetch byte address is the word PC times 4. With instruction map bit 12 clear, the fetch target is code 1, segment 0, offset equal to the 18-bit byte address, and no bus error.
- R8: With instruction map bit 12 set, the fetch target is code 2, segment imap[7:0], offset equal to the low 17 bits of the byte address. A segment value of 128 or more is not present and raises the fetch bus error.
- R9: The word PC resets synchronously (active low) to 0xFFC0. When pc_load is high at a clock edge it takes pc_in; otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the program counter |
| rst_n | input | 1 | Synchronous active-low reset |
| d_addr | input | 16 | Core data address |
| dmap | input | 16 | Data map value |
| imap | input | 16 | Instruction map value |
| seg_present | input | 128 | One bit per unified segment, set when present |
| pc_load | input | 1 | Load pc_in into the word PC |
| pc_in | input | 16 | New word PC |
| d_tgt | output | 2 | Data target: 0 data, 1 instruction, 2 unified |
| d_seg | output | 7 | Data unified segment |
| d_off | output | 18 | Data physical offset |
| d_berr | output | 1 | Data bus error |
| f_pc | output | 16 | Current word PC |
| f_tgt | output | 2 | Fetch target code |
| f_seg | output | 8 | Fetch unified segment |
| f_off | output | 18 | Fetch physical offset |
| f_berr | output | 1 | Fetch bus error |

## Verification
The bench builds the mapper with its default parameters: a 16 KB slot, 128 segments, the window at the third quarter and the I/O block at 0xFF00. With these values every slot index, the highest segment and the window and I/O boundaries can be reached by direct stimulus. Using a 16-bit word PC lets a PC of 0xFFFF show the cut to 17 bits in unified fetch. An 8-bit fetch segment field reaches values of 128 and above, which can never be present.

// File: rtl/bank_map_pkg.sv
// Package: shared target encoding for the address mapper.
// Assumes: consumers decode the target code as a 2-bit field.
package bank_map_pkg;
    typedef enum logic [1:0] {
        TGT_DATA = 2'd0,
        TGT_IMEM = 2'd1,
        TGT_UMEM = 2'd2
    } tgt_e;
endpackage

// File: rtl/data_xlate.sv
// Module: data_xlate
// Classifies a data address into plain / window / I/O region and
// translates window accesses through the data map value.
// Assumes: the slot is SLOT_W bits and both memories are a whole
// number of slots; clk/rst_n serve only the assertions.
module data_xlate
    import bank_map_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int SLOT_W   = 14,
    parameter int MAP_W    = 16,
    parameter int SEG_W    = 7,
    parameter int IMEM_W   = 18,
    parameter int UMEM_W   = 17,
    parameter int SEL_BIT  = 12,
    parameter int IO_LSB   = 4,
    parameter logic [1:0] WIN_REGION = 2'b10,
    parameter logic [1:0] IO_REGION  = 2'b11,
    parameter logic [15:0] IO_OK_BASE = 16'hFF00
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   d_addr,
    input  logic [MAP_W-1:0]    dmap,
    input  logic [(1<<SEG_W)-1:0] seg_present,
    output logic [1:0]          d_tgt,
    output logic [SEG_W-1:0]    d_seg,
    output logic [IMEM_W-1:0]   d_off,
    output logic                d_berr
);
    localparam int IMEM_SLOT_W = IMEM_W - SLOT_W;
    localparam int UMEM_SLOT_W = UMEM_W - SLOT_W;
    localparam int OFF_W       = IMEM_W;

    logic [ADDR_W-SLOT_W-1:0] region;
    logic                     in_win;
    logic                     in_io;
    logic                     io_ok;
    logic [SEG_W-1:0]         useg;
    logic [IMEM_W-1:0]        imem_off;
    logic [UMEM_W-1:0]        umem_off;

    // Purpose: decode the region and the legal I/O block.
    always_comb begin
        region = d_addr[ADDR_W-1:SLOT_W];
        in_win = (region == WIN_REGION);
        in_io  = (region == IO_REGION);
        io_ok  = (d_addr[ADDR_W-1:IO_LSB] == IO_OK_BASE[ADDR_W-1:IO_LSB]);
    end

    // Purpose: form both candidate window offsets from slot and low bits.
    always_comb begin
        useg     = dmap[UMEM_SLOT_W +: SEG_W];
        imem_off = {dmap[IMEM_SLOT_W-1:0], d_addr[SLOT_W-1:0]};
        umem_off = {dmap[UMEM_SLOT_W-1:0], d_addr[SLOT_W-1:0]};
    end

    // Purpose: select target, segment, offset and error flag.
    always_comb begin
        d_tgt  = TGT_DATA;
        d_seg  = '0;
        d_off  = OFF_W'(d_addr);
        d_berr = 1'b0;
        if (in_win) begin
            if (dmap[SEL_BIT]) begin
                d_tgt = TGT_IMEM;
                d_off = imem_off;
            end else begin
                d_tgt  = TGT_UMEM;
                d_seg  = useg;
                d_off  = OFF_W'(umem_off);
                d_berr = !seg_present[useg];
            end
        end else if (in_io) begin
            d_berr = !io_ok;
        end
    end

    AST_D_UMEM_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        (d_tgt == TGT_UMEM && !d_berr) |-> seg_present[d_seg]); // R5
    AST_D_PLAIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (d_tgt == TGT_DATA) |-> (d_off == OFF_W'(d_addr))); // R1
    AST_D_BERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        d_berr |-> (d_tgt == TGT_UMEM || d_addr[ADDR_W-1:SLOT_W] == IO_REGION)); // R4
    AST_D_WIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (d_tgt != TGT_DATA) |-> (d_off[SLOT_W-1:0] == d_addr[SLOT_W-1:0])); // R2
endmodule

// File: rtl/fetch_xlate.sv
// Module: fetch_xlate
// Turns the word PC into a byte address and routes it through the
// instruction map value to instruction or unified memory.
// Assumes: PC_W + 2 == IMEM_W and IMAP_SEG_W > SEG_W.
module fetch_xlate
    import bank_map_pkg::*;
#(
    parameter int PC_W       = 16,
    parameter int MAP_W      = 16,
    parameter int SEG_W      = 7,
    parameter int IMAP_SEG_W = 8,
    parameter int IMEM_W     = 18,
    parameter int UMEM_W     = 17,
    parameter int SEL_BIT    = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PC_W-1:0]       pc,
    input  logic [MAP_W-1:0]      imap,
    input  logic [(1<<SEG_W)-1:0] seg_present,
    output logic [1:0]            f_tgt,
    output logic [IMAP_SEG_W-1:0] f_seg,
    output logic [IMEM_W-1:0]     f_off,
    output logic                  f_berr
);
    localparam int BYTE_W = PC_W + 2;

    logic [BYTE_W-1:0]     pc_byte;
    logic [IMAP_SEG_W-1:0] iseg;
    logic                  seg_in_range;

    // Purpose: byte address and requested segment.
    always_comb begin
        pc_byte      = {pc, 2'b00};
        iseg         = imap[IMAP_SEG_W-1:0];
        seg_in_range = (iseg[IMAP_SEG_W-1:SEG_W] == '0);
    end

    // Purpose: select fetch target and flag missing segments.
    always_comb begin
        if (imap[SEL_BIT]) begin
            f_tgt  = TGT_UMEM;
            f_seg  = iseg;
            f_off  = IMEM_W'(pc_byte[UMEM_W-1:0]);
            f_berr = !(seg_in_range && seg_present[iseg[SEG_W-1:0]]);
        end else begin
            f_tgt  = TGT_IMEM;
            f_seg  = '0;
            f_off  = IMEM_W'(pc_byte);
            f_berr = 1'b0;
        end
    end

    AST_F_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        f_off[1:0] == 2'b00); // R7
    AST_F_UMEM_TRUNC: assert property (@(posedge clk) disable iff (!rst_n)
        (f_tgt == TGT_UMEM) |-> (f_off[IMEM_W-1:UMEM_W] == '0)); // R8
    AST_F_IMEM_NOERR: assert property (@(posedge clk) disable iff (!rst_n)
        (f_tgt == TGT_IMEM) |-> !f_berr); // R7
endmodule

// File: rtl/fetch_pc.sv
// Module: fetch_pc
// Holds the word program counter: reset vector, load, otherwise hold.
// Assumes: synchronous active-low reset.
module fetch_pc #(
    parameter int          PC_W     = 16,
    parameter logic [15:0] RESET_PC = 16'hFFC0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pc_load,
    input  logic [PC_W-1:0] pc_in,
    output logic [PC_W-1:0] pc
);
    // Purpose: reset to the vector, else load or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= RESET_PC[PC_W-1:0];
        else if (pc_load)
            pc <= pc_in;
    end

    AST_PC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> (pc == $past(pc_in))); // R9
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_load |=> $stable(pc)); // R9
endmodule

// File: rtl/bank_addr_mapper.sv
// Module: bank_addr_mapper (top)
// Data-side window mapping plus fetch-side mapping with a resident PC.
// Assumes: map values and the present mask are stable when used.
module bank_addr_mapper
    import bank_map_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int MAP_W      = 16,
    parameter int SEG_W      = 7,
    parameter int IMAP_SEG_W = 8,
    parameter int PC_W       = 16,
    parameter int IMEM_W     = 18,
    parameter int UMEM_W     = 17
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     d_addr,
    input  logic [MAP_W-1:0]      dmap,
    input  logic [MAP_W-1:0]      imap,
    input  logic [(1<<SEG_W)-1:0] seg_present,
    input  logic                  pc_load,
    input  logic [PC_W-1:0]       pc_in,
    output logic [1:0]            d_tgt,
    output logic [SEG_W-1:0]      d_seg,
    output logic [IMEM_W-1:0]     d_off,
    output logic                  d_berr,
    output logic [PC_W-1:0]       f_pc,
    output logic [1:0]            f_tgt,
    output logic [IMAP_SEG_W-1:0] f_seg,
    output logic [IMEM_W-1:0]     f_off,
    output logic                  f_berr
);
    data_xlate #(
        .ADDR_W(ADDR_W), .MAP_W(MAP_W), .SEG_W(SEG_W),
        .IMEM_W(IMEM_W), .UMEM_W(UMEM_W)
    ) i_data_xlate (
        .clk(clk), .rst_n(rst_n), .d_addr(d_addr), .dmap(dmap),
        .seg_present(seg_present), .d_tgt(d_tgt), .d_seg(d_seg),
        .d_off(d_off), .d_berr(d_berr)
    );

    fetch_pc #(.PC_W(PC_W)) i_fetch_pc (
        .clk(clk), .rst_n(rst_n), .pc_load(pc_load), .pc_in(pc_in), .pc(f_pc)
    );

    fetch_xlate #(
        .PC_W(PC_W), .MAP_W(MAP_W), .SEG_W(SEG_W), .IMAP_SEG_W(IMAP_SEG_W),
        .IMEM_W(IMEM_W), .UMEM_W(UMEM_W)
    ) i_fetch_xlate (
        .clk(clk), .rst_n(rst_n), .pc(f_pc), .imap(imap),
        .seg_present(seg_present), .f_tgt(f_tgt), .f_seg(f_seg),
        .f_off(f_off), .f_berr(f_berr)
    );
endmodule

// File: tb/test_bank_addr_mapper.sv
module test_bank_addr_mapper;
    localparam int CLK_P = 10;

    typedef struct {
        string       tag;
        logic [1:0]  dt;
        logic [6:0]  ds;
        logic [17:0] dof;
        logic        de;
        logic [15:0] pc;
        logic [1:0]  ft;
        logic [7:0]  fs;
        logic [17:0] fof;
        logic        fe;
    } exp_t;

    logic         clk = 0;
    logic         rst_n = 0;
    logic [15:0]  d_addr = 0, dmap = 0, imap = 0, pc_in = 0;
    logic [127:0] seg_present = 0;
    logic         pc_load = 0;
    logic [1:0]   d_tgt, f_tgt;
    logic [6:0]   d_seg;
    logic [7:0]   f_seg;
    logic [17:0]  d_off, f_off;
    logic         d_berr, f_berr;
    logic [15:0]  f_pc;

    int   total = 0, bad = 0;
    bit   done = 0;
    exp_t q[$];
    logic [15:0] model_pc = 16'hFFC0;

    bank_addr_mapper i_bank_addr_mapper (
        .clk(clk), .rst_n(rst_n), .d_addr(d_addr), .dmap(dmap), .imap(imap),
        .seg_present(seg_present), .pc_load(pc_load), .pc_in(pc_in),
        .d_tgt(d_tgt), .d_seg(d_seg), .d_off(d_off), .d_berr(d_berr),
        .f_pc(f_pc), .f_tgt(f_tgt), .f_seg(f_seg), .f_off(f_off), .f_berr(f_berr)
    );

    always #(CLK_P/2) clk = ~clk;

    // Driver: apply one input set per cycle and queue its expected outputs.
    task automatic drive(string tag, logic [15:0] a, logic [15:0] dm,
                         logic [15:0] im, logic [127:0] pres,
                         logic ld, logic [15:0] pin);
        exp_t e;
        logic [17:0] pb;
        @(negedge clk);
        d_addr = a; dmap = dm; imap = im; seg_present = pres;
        pc_load = ld; pc_in = pin;
        e.tag = tag;
        e.dt = 2'd0; e.ds = 0; e.dof = {2'b00, a}; e.de = 0;
        if (a[15:14] == 2'b10) begin
            if (dm[12]) begin
                e.dt = 2'd1; e.dof = dm[3:0] * 18'h4000 + a[13:0];
            end else begin
                e.dt = 2'd2; e.ds = dm[9:3];
                e.dof = dm[2:0] * 18'h4000 + a[13:0];
                e.de = !pres[dm[9:3]];
            end
        end else if (a[15:14] == 2'b11) begin
            e.de = (a[15:4] != 12'hFF0);
        end
        e.pc = model_pc;
        pb = model_pc * 4;
        if (im[12]) begin
            e.ft = 2'd2; e.fs = im[7:0]; e.fof = pb % 18'h20000;
            e.fe = (im[7:0] >= 128) ? 1'b1 : !pres[im[6:0]];
        end else begin
            e.ft = 2'd1; e.fs = 0; e.fof = pb; e.fe = 0;
        end
        q.push_back(e);
        if (ld) model_pc = pin;
    endtask

    // Monitor: compare outputs a quarter period after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (d_tgt !== e.dt || d_seg !== e.ds || d_off !== e.dof ||
                    d_berr !== e.de || f_pc !== e.pc || f_tgt !== e.ft ||
                    f_seg !== e.fs || f_off !== e.fof || f_berr !== e.fe) begin
                    bad++;
                    $display("FAIL %s: got d=%0d/%0h/%0h/%0b pc=%0h f=%0d/%0h/%0h/%0b exp d=%0d/%0h/%0h/%0b pc=%0h f=%0d/%0h/%0h/%0b",
                        e.tag, d_tgt, d_seg, d_off, d_berr, f_pc, f_tgt, f_seg, f_off, f_berr,
                        e.dt, e.ds, e.dof, e.de, e.pc, e.ft, e.fs, e.fof, e.fe);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: got running expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [127:0] all_p;
        logic [127:0] some_p;
        all_p  = '1;
        some_p = '0;
        some_p[3] = 1; some_p[127] = 1; some_p[40] = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        drive("R9 reset vector", 16'h0000, 16'h0000, 16'h0000, '0, 0, 0);
        drive("R1 plain", 16'h1234, 16'h101F, 16'h0000, all_p, 0, 0);
        drive("R6 0x7FFF plain", 16'h7FFF, 16'h0000, 16'h0000, all_p, 0, 0);
        drive("R2 imem slot5", 16'h8ABC, 16'h1005, 16'h0000, all_p, 0, 0);
        drive("R2 imem slot15", 16'hBFFF, 16'h100F, 16'h0000, all_p, 0, 0);
        drive("R3 umem seg3", 16'h9001, 16'h001A, 16'h0000, some_p, 0, 0);
        drive("R3 ignored bits", 16'h9001, 16'hEC1A, 16'h0000, some_p, 0, 0);
        drive("R3 seg127", 16'h8000, 16'h03FF, 16'h0000, some_p, 0, 0);
        drive("R5 seg absent", 16'h8123, 16'h0010, 16'h0000, some_p, 0, 0);
        drive("R6 0x8000", 16'h8000, 16'h1000, 16'h0000, all_p, 0, 0);
        drive("R4 io 0xFF00", 16'hFF00, 16'h0000, 16'h0000, all_p, 0, 0);
        drive("R4 io 0xFF0F", 16'hFF0F, 16'h0000, 16'h0000, all_p, 0, 0);
        drive("R4 io 0xFF10", 16'hFF10, 16'h0000, 16'h0000, all_p, 0, 0);
        drive("R6 0xC000", 16'hC000, 16'h1000, 16'h0000, all_p, 0, 0);
        drive("R4 io 0xFEFF", 16'hFEFF, 16'h0000, 16'h0000, all_p, 1, 16'hFFFF);
        drive("R8 fetch umem trunc", 16'h0000, 16'h0000, 16'h1028, some_p, 0, 0);
        drive("R8 fetch seg>=128", 16'h0000, 16'h0000, 16'h1080, all_p, 0, 0);
        drive("R5 fetch seg absent", 16'h0000, 16'h0000, 16'h1005, some_p, 0, 0);
        drive("R7 fetch imem", 16'h0000, 16'h0000, 16'h00FF, '0, 1, 16'h1235);
        drive("R9 load", 16'h0000, 16'h0000, 16'h0000, '0, 0, 16'h0BAD);
        drive("R9 hold", 16'h0000, 16'h0000, 16'h107F, some_p, 0, 16'h7777);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        model_pc = 16'hFFC0;
        drive("R9 re-reset", 16'h0000, 16'h0000, 16'h0000, '0, 0, 0);
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule